// File: doc/BRIEF.md
# DMA Request Router for Audio FIFO Channels

This block sits between a bank of per-channel audio FIFOs and a DMA engine that offers a small number of request/acknowledge line pairs. Each FIFO channel reports a watermark condition: a capture channel flags that it is almost full, and a playback channel flags that it is almost empty. The router picks, for every DMA request line, which FIFO channel drives it. For every FIFO channel, it picks which DMA acknowledge line returns a transfer strobe to that channel. Capture and playback have fully separate crossbars.

Configuration is held in seven write-only configuration words reached through a simple write port. One word holds the DMA enables for both directions. Two words hold the per-line source selectors. Four words hold the per-channel acknowledge selectors, with one low/high pair per direction. When a channel's DMA enable bit changes, the router emits a one-cycle clear strobe towards that channel's FIFO, so the FIFO is flushed when DMA mode is entered and again when it is left. All outputs are registered.

Top module: `dmarr_router`

## Requirements
- R1: While reset is asserted, and afterwards until configuration is written, every request, pop, push and clear output is low, even when all watermark and acknowledge inputs are high.
- R2: A write to address 0 sets the capture enables from data bits 9:0 and the playback enables from data bits 25:16. All other data bits of that word are ignored.
- R3: A capture request line is high one cycle after its selected channel is enabled and has almost-full set. A playback request line behaves the same way with almost-empty. Otherwise the line is low.
- R4: Line k takes its 4-bit source channel from bits 4k+3:4k of address 1 for playback and of address 2 for capture.
- R5: A source select value of 10 or more drives its request line low.
- R6: The acknowledge select of channel c (0–7) sits at bits 4c+3:4c of the low word. Channels 8 and 9 sit at bits 3:0 and 7:4 of the high word. Playback uses addresses 3 (low) and 4 (high). Capture uses addresses 5 (low) and 6 (high).
- R7: An acknowledge high on line k in a cycle produces, one cycle later, a single-cycle strobe on every enabled channel of that direction whose acknowledge select equals k. Several channels may share one line.
- R8: An acknowledge select value of 5 or more never produces a strobe.
- R9: A channel whose enable bit is clear produces neither a strobe nor a request.
- R10: A write to address 0 produces, one cycle later, a single-cycle clear strobe on exactly the channels whose enable bit changed, in each direction separately.
- R11: Capture acknowledges affect only capture pops, and playback acknowledges affect only playback pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cap_af | input | 10 | Per-channel capture almost-full condition |
| play_ae | input | 10 | Per-channel playback almost-empty condition |
| cap_ack | input | 5 | Capture DMA acknowledge lines |
| play_ack | input | 5 | Playback DMA acknowledge lines |
| cap_req | output | 5 | Capture DMA request lines |
| play_req | output | 5 | Playback DMA request lines |
| cap_pop | output | 10 | Per-channel capture pop strobes |
| play_push | output | 10 | Per-channel playback push strobes |
| cap_clr | output | 10 | Per-channel capture FIFO clear strobes |
| play_clr | output | 10 | Per-channel playback FIFO clear strobes |

## Verification
The bench targets four risks. The first is the split acknowledge packing for channels 8 and 9: a design that reads it wrongly strobes the wrong channel or none at all. The second is out-of-range selectors (source 15, acknowledge 6 and 7): a design that indexes without a range check fires a line, or wraps to a live channel. The third is two channels sharing one acknowledge line, where a priority encoder in place of a fan-out would drop one strobe. The fourth is enable writes with junk in the unused bits, plus enable changes in both directions: a design that compares the wrong fields would emit clear strobes on untouched channels or miss toggled ones.

// File: rtl/dmarr_pkg.sv
`timescale 1ns/1ps
package dmarr_pkg;
  typedef enum logic [2:0] {
    A_ENABLE      = 3'd0,
    A_PLAY_SRC    = 3'd1,
    A_CAP_SRC     = 3'd2,
    A_PLAY_ACK_LO = 3'd3,
    A_PLAY_ACK_HI = 3'd4,
    A_CAP_ACK_LO  = 3'd5,
    A_CAP_ACK_HI  = 3'd6
  } cfg_addr_e;

  localparam int PLAY_EN_BASE = 16;
endpackage

// File: rtl/dmarr_cfg.sv
`timescale 1ns/1ps
module dmarr_cfg
  import dmarr_pkg::*;
#(
  parameter int NCH   = 10,
  parameter int NLINE = 5,
  parameter int SELW  = 4,
  parameter int DW    = 32,
  parameter int APW   = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [2:0]                      addr,
  input  logic [DW-1:0]                   wdata,
  output logic [NCH-1:0]                  en_cap,
  output logic [NCH-1:0]                  en_play,
  output logic [NLINE-1:0][SELW-1:0]      src_cap,
  output logic [NLINE-1:0][SELW-1:0]      src_play,
  output logic [NCH-1:0][SELW-1:0]        ack_cap,
  output logic [NCH-1:0][SELW-1:0]        ack_play,
  output logic [NCH-1:0]                  clr_cap,
  output logic [NCH-1:0]                  clr_play
);
  logic [NCH-1:0]             en_cap_d, en_play_d, clr_cap_d, clr_play_d;
  logic [NLINE-1:0][SELW-1:0] src_cap_d, src_play_d;
  logic [NCH-1:0][SELW-1:0]   ack_cap_d, ack_play_d;

  always_comb begin
    en_cap_d   = en_cap;
    en_play_d  = en_play;
    src_cap_d  = src_cap;
    src_play_d = src_play;
    ack_cap_d  = ack_cap;
    ack_play_d = ack_play;
    clr_cap_d  = '0;
    clr_play_d = '0;
    if (we) begin
      case (cfg_addr_e'(addr))
        A_ENABLE: begin
          en_cap_d   = wdata[NCH-1:0];
          en_play_d  = wdata[PLAY_EN_BASE +: NCH];
          clr_cap_d  = en_cap ^ wdata[NCH-1:0];
          clr_play_d = en_play ^ wdata[PLAY_EN_BASE +: NCH];
        end
        A_PLAY_SRC:
          for (int k = 0; k < NLINE; k++) src_play_d[k] = wdata[k*SELW +: SELW];
        A_CAP_SRC:
          for (int k = 0; k < NLINE; k++) src_cap_d[k] = wdata[k*SELW +: SELW];
        A_PLAY_ACK_LO:
          for (int c = 0; c < NCH; c++)
            if (c < APW) ack_play_d[c] = wdata[(c % APW)*SELW +: SELW];
        A_PLAY_ACK_HI:
          for (int c = 0; c < NCH; c++)
            if (c >= APW) ack_play_d[c] = wdata[(c % APW)*SELW +: SELW];
        A_CAP_ACK_LO:
          for (int c = 0; c < NCH; c++)
            if (c < APW) ack_cap_d[c] = wdata[(c % APW)*SELW +: SELW];
        A_CAP_ACK_HI:
          for (int c = 0; c < NCH; c++)
            if (c >= APW) ack_cap_d[c] = wdata[(c % APW)*SELW +: SELW];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_cap   <= '0;
      en_play  <= '0;
      src_cap  <= '0;
      src_play <= '0;
      ack_cap  <= '0;
      ack_play <= '0;
      clr_cap  <= '0;
      clr_play <= '0;
    end else begin
      en_cap   <= en_cap_d;
      en_play  <= en_play_d;
      src_cap  <= src_cap_d;
      src_play <= src_play_d;
      ack_cap  <= ack_cap_d;
      ack_play <= ack_play_d;
      clr_cap  <= clr_cap_d;
      clr_play <= clr_play_d;
    end
  end
endmodule

// File: rtl/dmarr_req_xbar.sv
`timescale 1ns/1ps
module dmarr_req_xbar #(
  parameter int NCH   = 10,
  parameter int NLINE = 5,
  parameter int SELW  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCH-1:0]             en,
  input  logic [NCH-1:0]             cond,
  input  logic [NLINE-1:0][SELW-1:0] src,
  output logic [NLINE-1:0]           req
);
  logic [NLINE-1:0] req_d;

  for (genvar k = 0; k < NLINE; k++) begin : g_line
    always_comb begin
      req_d[k] = 1'b0;
      for (int j = 0; j < NCH; j++)
        if (src[k] == SELW'(j)) req_d[k] = en[j] & cond[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= '0;
    else        req <= req_d;
  end
endmodule

// File: rtl/dmarr_ack_fanout.sv
`timescale 1ns/1ps
module dmarr_ack_fanout #(
  parameter int NCH   = 10,
  parameter int NLINE = 5,
  parameter int SELW  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           en,
  input  logic [NCH-1:0][SELW-1:0] sel,
  input  logic [NLINE-1:0]         ack,
  output logic [NCH-1:0]           strobe
);
  logic [NCH-1:0] strobe_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      strobe_d[c] = 1'b0;
      for (int l = 0; l < NLINE; l++)
        if (sel[c] == SELW'(l)) strobe_d[c] = en[c] & ack[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= '0;
    else        strobe <= strobe_d;
  end
endmodule

// File: rtl/dmarr_router.sv
`timescale 1ns/1ps
module dmarr_router #(
  parameter int NCH   = 10,
  parameter int NLINE = 5,
  parameter int SELW  = 4,
  parameter int DW    = 32,
  parameter int APW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic [NCH-1:0]  cap_af,
  input  logic [NCH-1:0]  play_ae,
  input  logic [NLINE-1:0] cap_ack,
  input  logic [NLINE-1:0] play_ack,
  output logic [NLINE-1:0] cap_req,
  output logic [NLINE-1:0] play_req,
  output logic [NCH-1:0]  cap_pop,
  output logic [NCH-1:0]  play_push,
  output logic [NCH-1:0]  cap_clr,
  output logic [NCH-1:0]  play_clr
);
  logic [NCH-1:0]             en_cap, en_play;
  logic [NLINE-1:0][SELW-1:0] src_cap, src_play;
  logic [NCH-1:0][SELW-1:0]   ack_cap, ack_play;

  dmarr_cfg #(.NCH(NCH), .NLINE(NLINE), .SELW(SELW), .DW(DW), .APW(APW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en_cap(en_cap), .en_play(en_play), .src_cap(src_cap), .src_play(src_play),
    .ack_cap(ack_cap), .ack_play(ack_play), .clr_cap(cap_clr), .clr_play(play_clr)
  );

  dmarr_req_xbar #(.NCH(NCH), .NLINE(NLINE), .SELW(SELW)) u_cap_xbar (
    .clk(clk), .rst_n(rst_n), .en(en_cap), .cond(cap_af), .src(src_cap), .req(cap_req)
  );

  dmarr_req_xbar #(.NCH(NCH), .NLINE(NLINE), .SELW(SELW)) u_play_xbar (
    .clk(clk), .rst_n(rst_n), .en(en_play), .cond(play_ae), .src(src_play), .req(play_req)
  );

  dmarr_ack_fanout #(.NCH(NCH), .NLINE(NLINE), .SELW(SELW)) u_cap_ack (
    .clk(clk), .rst_n(rst_n), .en(en_cap), .sel(ack_cap), .ack(cap_ack), .strobe(cap_pop)
  );

  dmarr_ack_fanout #(.NCH(NCH), .NLINE(NLINE), .SELW(SELW)) u_play_ack (
    .clk(clk), .rst_n(rst_n), .en(en_play), .sel(ack_play), .ack(play_ack), .strobe(play_push)
  );
endmodule

// File: rtl/dmarr_chk.sv
`timescale 1ns/1ps
module dmarr_chk #(
  parameter int NCH   = 10,
  parameter int NLINE = 5,
  parameter int SELW  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_we,
  input logic [2:0]                 cfg_addr,
  input logic [NCH-1:0]             cap_af,
  input logic [NLINE-1:0]           cap_ack,
  input logic [NLINE-1:0]           play_ack,
  input logic [NLINE-1:0]           cap_req,
  input logic [NCH-1:0]             cap_pop,
  input logic [NCH-1:0]             play_push,
  input logic [NCH-1:0]             cap_clr,
  input logic [NCH-1:0]             play_clr,
  input logic [NCH-1:0]             en_cap,
  input logic [NLINE-1:0][SELW-1:0] src_cap,
  input logic [NCH-1:0][SELW-1:0]   ack_cap
);
  // R7: a capture pop only follows a capture acknowledge
  a_r7_pop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (|cap_pop) |-> $past(|cap_ack));

  // R11: a playback push only follows a playback acknowledge
  a_r11_push_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (|play_push) |-> $past(|play_ack));

  // R10: clear strobes only follow a write to the enable word
  a_r10_clr_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cap_clr) || (|play_clr)) |-> $past(cfg_we && cfg_addr == 3'd0));

  for (genvar k = 0; k < NLINE; k++) begin : g_line_chk
    // R5: a request never comes from an out-of-range source
    a_r5_src_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cap_req[k] |-> $past(src_cap[k] < SELW'(NCH)));
    // R3: a capture request needs some almost-full condition
    a_r3_req_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
      cap_req[k] |-> $past(|cap_af));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch_chk
    // R9: a strobe needs the channel enabled
    a_r9_pop_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pop[c] |-> $past(en_cap[c]));
    // R8: a strobe needs a valid acknowledge line select
    a_r8_pop_valid_sel: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pop[c] |-> $past(ack_cap[c] < SELW'(NLINE)));
  end
endmodule

bind dmarr_router dmarr_chk #(.NCH(NCH), .NLINE(NLINE), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cap_af(cap_af),
  .cap_ack(cap_ack), .play_ack(play_ack), .cap_req(cap_req), .cap_pop(cap_pop),
  .play_push(play_push), .cap_clr(cap_clr), .play_clr(play_clr), .en_cap(en_cap),
  .src_cap(src_cap), .ack_cap(ack_cap)
);

// File: tb/tb_dmarr_router.sv
`timescale 1ns/1ps
module tb_dmarr_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [9:0]  cap_af = '0, play_ae = '0;
  logic [4:0]  cap_ack = '0, play_ack = '0;
  logic [4:0]  cap_req, play_req;
  logic [9:0]  cap_pop, play_push, cap_clr, play_clr;

  always #10 clk = ~clk;

  dmarr_router dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cap_af(cap_af), .play_ae(play_ae), .cap_ack(cap_ack), .play_ack(play_ack),
    .cap_req(cap_req), .play_req(play_req), .cap_pop(cap_pop), .play_push(play_push),
    .cap_clr(cap_clr), .play_clr(play_clr)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [49:0] exp_q[$];
  string       tag_q[$];

  // reference model of the configuration, built from the requirements
  bit [9:0] m_en_c, m_en_p;
  bit [3:0] m_src_c[5], m_src_p[5], m_ack_c[10], m_ack_p[10];

  function automatic logic [49:0] outs();
    return {cap_req, play_req, cap_pop, play_push, cap_clr, play_clr};
  endfunction

  task automatic cmp(input string tag, input logic [49:0] act, input logic [49:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // driver: one cycle of stimulus plus its expected result
  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d,
                      input logic [9:0] af, input logic [9:0] ae,
                      input logic [4:0] ca, input logic [4:0] pa, input string tag);
    logic [4:0] ecr, epr;
    logic [9:0] ecp, epp, ecc, epc;
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    cap_af = af; play_ae = ae; cap_ack = ca; play_ack = pa;
    for (int k = 0; k < 5; k++) begin
      ecr[k] = (m_src_c[k] < 10) && m_en_c[m_src_c[k]] && af[m_src_c[k]];
      epr[k] = (m_src_p[k] < 10) && m_en_p[m_src_p[k]] && ae[m_src_p[k]];
    end
    for (int c = 0; c < 10; c++) begin
      ecp[c] = m_en_c[c] && (m_ack_c[c] < 5) && ca[m_ack_c[c]];
      epp[c] = m_en_p[c] && (m_ack_p[c] < 5) && pa[m_ack_p[c]];
    end
    ecc = '0; epc = '0;
    if (we) begin
      case (a)
        3'd0: begin
          ecc = m_en_c ^ d[9:0]; epc = m_en_p ^ d[25:16];
          m_en_c = d[9:0]; m_en_p = d[25:16];
        end
        3'd1: for (int k = 0; k < 5; k++) m_src_p[k] = d[4*k +: 4];
        3'd2: for (int k = 0; k < 5; k++) m_src_c[k] = d[4*k +: 4];
        3'd3: for (int c = 0; c < 8; c++) m_ack_p[c] = d[4*c +: 4];
        3'd4: begin m_ack_p[8] = d[3:0]; m_ack_p[9] = d[7:4]; end
        3'd5: for (int c = 0; c < 8; c++) m_ack_c[c] = d[4*c +: 4];
        3'd6: begin m_ack_c[8] = d[3:0]; m_ack_c[9] = d[7:4]; end
        default: ;
      endcase
    end
    exp_q.push_back({ecr, epr, ecp, epp, ecc, epc});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 3'd0, 32'd0, 10'd0, 10'd0, 5'd0, 5'd0, tag);
  endtask

  // monitor: compare away from the clock edge
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) cmp(tag_q.pop_front(), outs(), exp_q.pop_front());
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cap_af = '1; play_ae = '1; cap_ack = '1; play_ack = '1;
    #1 cmp("R1 outputs in reset", outs(), 50'd0);
    rst_n = 1'b1;
    step(0, 0, 0, '1, '1, '1, '1, "R1 idle after reset");
    step(0, 0, 0, '1, '1, '1, '1, "R9 nothing enabled");
    // enable capture 0,2 and playback 0,1; junk in unused bits (R2, R10)
    step(1, 0, 32'hFC03_FC05, 0, 0, 0, 0, "R2 R10 enable write");
    // capture sources: line0=2 line1=0 line2=15 line3=1 line4=2 (R4, R5)
    step(1, 2, 32'h0002_1F02, 0, 0, 0, 0, "R4 cap src write");
    // playback sources: line0=1 line1=0 line2=12 line3=3 line4=9
    step(1, 1, 32'h0009_3C01, 0, 0, 0, 0, "R4 play src write");
    step(0, 0, 0, 10'h3FF, 10'h000, 0, 0, "R3 R5 all almost-full");
    step(0, 0, 0, 10'h004, 10'h002, 0, 0, "R3 single sources");
    step(0, 0, 0, 10'h001, 10'h3FF, 0, 0, "R3 R9 playback all");
    step(0, 0, 0, 10'h002, 10'h200, 0, 0, "R9 disabled sources");
    // capture ack: ch0->3 ch1->0 ch2->3 others 0; ch8->1 ch9->7
    step(1, 5, 32'h0000_0303, 0, 0, 0, 0, "R6 cap ack lo write");
    step(1, 6, 32'h0000_0071, 0, 0, 0, 0, "R6 cap ack hi write");
    // playback ack: ch0->4 ch1->6 others 0; ch8->2 ch9->3
    step(1, 3, 32'h0000_0064, 0, 0, 0, 0, "R6 play ack lo write");
    step(1, 4, 32'h0000_0032, 0, 0, 0, 0, "R6 play ack hi write");
    step(0, 0, 0, 0, 0, 5'b01000, 0, "R7 shared capture line");
    step(0, 0, 0, 0, 0, 0, 5'b10000, "R7 R11 playback line4");
    step(0, 0, 0, 0, 0, 5'b00001, 5'b01000, "R8 R9 R11 mixed ack");
    step(0, 0, 0, 0, 0, 5'b11111, 5'b11111, "R7 R8 all ack");
    // enable capture 8,9 and playback 8, drop capture 2 (R10)
    step(1, 0, 32'h0103_0301, 0, 0, 0, 0, "R10 enable change");
    step(0, 0, 0, 0, 0, 5'b00010, 5'b00100, "R6 R7 high channels");
    step(0, 0, 0, 0, 0, 5'b11111, 5'b11111, "R8 R9 after change");
    step(0, 0, 0, 10'h3FF, 10'h3FF, 0, 0, "R3 R4 after change");
    step(1, 0, 32'h0000_0000, 0, 0, 5'b11111, 5'b11111, "R10 disable all");
    step(0, 0, 0, 10'h3FF, 10'h3FF, 5'b11111, 5'b11111, "R9 all disabled");
    idle("R1 final idle");
    idle("R1 final idle");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule